// File: doc/BRIEF.md
# Mask Register Move Unit

This execution unit holds a small file of 64-bit opmask registers and carries out already-decoded move requests between them, a general-purpose register (GPR) result bus and a memory store/load path. Each request names an operation form, an element size (byte, word, doubleword or quadword), the processor mode (32-bit or 64-bit), the two-bit ModRM mode field and the source and destination mask register indices. It also carries GPR source data and memory load data.

Every destination kind follows its own width rule. A mask register write zero-extends the sized value to the full register width. A GPR write zero-extends the value to the width of the current mode. A memory store carries only the selected low bytes, marked by byte enables. Forms whose ModRM mode field does not match the form are rejected through a fault flag, and so are quadword GPR moves outside 64-bit mode and any GPR-to-GPR or GPR-to-memory request. A rejected request writes nothing. Results appear on registered outputs one clock after the request. No status flags are produced.

Top module: `maskmov_unit`

## Requirements
- R1: Form encoding: 0 = mask load (mask destination, source is a mask register or memory), 1 = mask store (memory destination), 2 = GPR to mask, 3 = mask to GPR. Size encoding: 0 = byte, 1 = word, 2 = doubleword, 3 = quadword. A mask register write keeps the low 8/16/32/64 source bits and clears every bit above them.
- R2: A mask-to-GPR move drives `gpr_we` with the sized value, zero-extended. In 32-bit mode (`req_mode64`=0), bits 63:32 of `gpr_wdata` are zero. A quadword move in 64-bit mode passes all 64 bits unchanged.
- R3: A mask store raises `st_valid`. `st_data` holds the sized value with zeros above it. `st_be` is 8'h01, 8'h03, 8'h0F or 8'hFF for byte, word, doubleword or quadword.
- R4: The GPR-to-mask and mask-to-GPR forms require `req_mod` = 2'b11. Any other value raises `fault` and performs no write.
- R5: The mask store form requires `req_mod` other than 2'b11. With 2'b11 it raises `fault` and performs no write.
- R6: A quadword GPR-to-mask or mask-to-GPR move with `req_mode64`=0 raises `fault` and writes nothing.
- R7: Form codes 4 to 7 (GPR-to-GPR, GPR-to-memory and reserved) raise `fault` and write nothing.
- R8: In the mask load form, `req_mod` = 2'b11 takes the source from mask register `req_ksrc`. Any other `req_mod` takes it from `mem_ld`.
- R9: Synchronous active-high reset clears all mask registers and all outputs to zero.
- R10: Outputs are valid exactly one clock after an accepted request and are zero in cycles with no request. A mask register written by one request is visible to a request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_form | input | 3 | Operation form |
| req_size | input | 2 | Element size |
| req_mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| req_mod | input | 2 | ModRM mode field |
| req_kdst | input | 3 | Destination mask register index |
| req_ksrc | input | 3 | Source mask register index |
| gpr_src | input | 64 | GPR source operand |
| mem_ld | input | 64 | Memory load data |
| gpr_we | output | 1 | GPR write-back strobe |
| gpr_wdata | output | 64 | GPR write-back data |
| st_valid | output | 1 | Memory store strobe |
| st_data | output | 64 | Store data, low-aligned |
| st_be | output | 8 | Store byte enables |
| fault | output | 1 | Invalid request flag |

## Verification
The mask registers cannot be seen directly at the ports. A wrong value in one of them stays hidden until a later mask-to-GPR move or mask store reads that register, and the difference then shows one clock after that read request. The bench therefore follows every mask write with a read-back. After every rejected request it reads the destination register again, which shows that a faulting request left the register unchanged. Decode errors (a wrong fault, enable or lane pattern) appear in the very next cycle.

// File: rtl/maskmov_pkg.sv
package maskmov_pkg;

  typedef enum logic [2:0] {
    FORM_KLOAD  = 3'd0,
    FORM_KSTORE = 3'd1,
    FORM_GPR2K  = 3'd2,
    FORM_K2GPR  = 3'd3
  } mm_form_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_D = 2'd2,
    SZ_Q = 2'd3
  } mm_size_e;

  localparam logic [1:0] MOD_REG = 2'b11;

  // Bit mask covering the low 8 << size bits of a 64-bit word.
  function automatic logic [63:0] size_bits(input logic [1:0] sz);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < (8 << sz)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Low-lane byte enables for a given size.
  function automatic logic [7:0] size_lanes(input logic [1:0] sz);
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < (1 << sz)) b[i] = 1'b1;
    end
    return b;
  endfunction

endpackage

// File: rtl/maskmov_decode.sv
module maskmov_decode
  import maskmov_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] form,
  input  logic [1:0] size,
  input  logic       mode64,
  input  logic [1:0] modf,
  output logic       k_we,
  output logic       gpr_we,
  output logic       st_we,
  output logic       bad,
  output logic       src_mem,
  output logic       src_gpr
);

  logic is_reg_mod;
  logic q_in_32;
  logic form_ok;

  always_comb begin
    is_reg_mod = (modf == MOD_REG);
    q_in_32    = (size == SZ_Q) && !mode64;
    form_ok    = 1'b0;
    k_we       = 1'b0;
    gpr_we     = 1'b0;
    st_we      = 1'b0;
    src_mem    = 1'b0;
    src_gpr    = 1'b0;
    unique case (form)
      FORM_KLOAD: begin
        form_ok = 1'b1;
        src_mem = !is_reg_mod;
      end
      FORM_KSTORE: form_ok = !is_reg_mod;
      FORM_GPR2K: begin
        form_ok = is_reg_mod && !q_in_32;
        src_gpr = 1'b1;
      end
      FORM_K2GPR: form_ok = is_reg_mod && !q_in_32;
      default:    form_ok = 1'b0;
    endcase
    if (valid && form_ok) begin
      k_we   = (form == FORM_KLOAD) || (form == FORM_GPR2K);
      st_we  = (form == FORM_KSTORE);
      gpr_we = (form == FORM_K2GPR);
    end
    bad = valid && !form_ok;
  end

endmodule

// File: rtl/maskmov_regfile.sv
module maskmov_regfile #(
  parameter int NUM_K = 8,
  parameter int KW    = 64,
  localparam int IW   = $clog2(NUM_K)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [KW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [KW-1:0] rdata
);

  logic [KW-1:0] kreg [NUM_K];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_K; i++) kreg[i] <= '0;
    end else if (we) begin
      kreg[waddr] <= wdata;
    end
  end

  assign rdata = kreg[raddr];

  logic any_set;
  always_comb begin
    any_set = 1'b0;
    for (int i = 0; i < NUM_K; i++) any_set = any_set | (|kreg[i]);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> !any_set); // R9

endmodule

// File: rtl/maskmov_outreg.sv
module maskmov_outreg #(
  parameter int KW  = 64,
  parameter int GW  = 64,
  localparam int BW = KW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gpr_we_d,
  input  logic          st_we_d,
  input  logic          bad_d,
  input  logic          mode64_d,
  input  logic [1:0]    size_d,
  input  logic [KW-1:0] value_d,
  output logic          gpr_we,
  output logic [GW-1:0] gpr_wdata,
  output logic          st_valid,
  output logic [KW-1:0] st_data,
  output logic [BW-1:0] st_be,
  output logic          fault
);
  import maskmov_pkg::*;

  logic [GW-1:0] gpr_val;
  logic          m64_q;

  always_comb begin
    gpr_val = GW'(value_d);
    if (!mode64_d) gpr_val[GW-1:GW/2] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gpr_we    <= 1'b0;
      gpr_wdata <= '0;
      st_valid  <= 1'b0;
      st_data   <= '0;
      st_be     <= '0;
      fault     <= 1'b0;
      m64_q     <= 1'b0;
    end else begin
      gpr_we    <= gpr_we_d;
      gpr_wdata <= gpr_we_d ? gpr_val : '0;
      st_valid  <= st_we_d;
      st_data   <= st_we_d ? value_d : '0;
      st_be     <= st_we_d ? BW'(size_lanes(size_d)) : '0;
      fault     <= bad_d;
      m64_q     <= mode64_d;
    end
  end

  logic [KW-1:0] lane_bits;
  always_comb begin
    for (int i = 0; i < KW; i++) lane_bits[i] = st_be[i/8];
  end

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!gpr_we && !st_valid)); // R4
  AST_STORE_LANES: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> ((st_data & ~lane_bits) == '0)); // R3
  AST_STORE_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (st_be == 8'h01 || st_be == 8'h03 || st_be == 8'h0F || st_be == 8'hFF)); // R3
  AST_GPR32_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (gpr_we && !m64_q) |-> (gpr_wdata[GW-1:GW/2] == '0)); // R2
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gpr_we, st_valid, fault})); // R10

endmodule

// File: rtl/maskmov_unit.sv
module maskmov_unit #(
  parameter int NUM_K = 8,
  parameter int KW    = 64,
  parameter int GW    = 64,
  localparam int IW   = $clog2(NUM_K),
  localparam int BW   = KW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_form,
  input  logic [1:0]    req_size,
  input  logic          req_mode64,
  input  logic [1:0]    req_mod,
  input  logic [IW-1:0] req_kdst,
  input  logic [IW-1:0] req_ksrc,
  input  logic [GW-1:0] gpr_src,
  input  logic [KW-1:0] mem_ld,
  output logic          gpr_we,
  output logic [GW-1:0] gpr_wdata,
  output logic          st_valid,
  output logic [KW-1:0] st_data,
  output logic [BW-1:0] st_be,
  output logic          fault
);
  import maskmov_pkg::*;

  logic          k_we, gwe_d, st_d, bad_d, src_mem, src_gpr;
  logic [KW-1:0] k_rd, raw, sized;

  maskmov_decode u_dec (
    .valid  (req_valid),
    .form   (req_form),
    .size   (req_size),
    .mode64 (req_mode64),
    .modf   (req_mod),
    .k_we   (k_we),
    .gpr_we (gwe_d),
    .st_we  (st_d),
    .bad    (bad_d),
    .src_mem(src_mem),
    .src_gpr(src_gpr)
  );

  always_comb begin
    if (src_gpr)      raw = KW'(gpr_src);
    else if (src_mem) raw = mem_ld;
    else              raw = k_rd;
    sized = raw & KW'(size_bits(req_size));
  end

  maskmov_regfile #(.NUM_K(NUM_K), .KW(KW)) u_kregs (
    .clk  (clk),
    .rst  (rst),
    .we   (k_we),
    .waddr(req_kdst),
    .wdata(sized),
    .raddr(req_ksrc),
    .rdata(k_rd)
  );

  maskmov_outreg #(.KW(KW), .GW(GW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .gpr_we_d (gwe_d),
    .st_we_d  (st_d),
    .bad_d    (bad_d),
    .mode64_d (req_mode64),
    .size_d   (req_size),
    .value_d  (sized),
    .gpr_we   (gpr_we),
    .gpr_wdata(gpr_wdata),
    .st_valid (st_valid),
    .st_data  (st_data),
    .st_be    (st_be),
    .fault    (fault)
  );

  AST_RR_NEEDS_REG_MOD: assert property (@(posedge clk) disable iff (rst)
    ((k_we || gwe_d) && (req_form == FORM_GPR2K || req_form == FORM_K2GPR)) |-> (req_mod == MOD_REG)); // R4
  AST_STORE_NEEDS_MEM_MOD: assert property (@(posedge clk) disable iff (rst)
    st_d |-> (req_mod != MOD_REG)); // R5
  AST_Q32_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_mode64 && req_size == SZ_Q &&
     (req_form == FORM_GPR2K || req_form == FORM_K2GPR)) |=> fault); // R6
  AST_BAD_FORM_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_form[2]) |=> (fault && !gpr_we && !st_valid)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!gpr_we && !st_valid && !fault)); // R10

endmodule

// File: tb/maskmov_unit_tb.sv
module maskmov_unit_tb_top;

  typedef struct packed {
    logic [2:0]  form;
    logic [1:0]  size;
    logic        m64;
    logic [1:0]  modf;
    logic [2:0]  kd;
    logic [2:0]  ks;
    logic [63:0] gpr;
    logic [63:0] mem;
    logic        gwe;
    logic [63:0] gd;
    logic        sv;
    logic [63:0] sd;
    logic [7:0]  be;
    logic        flt;
    logic [3:0]  req;
  } vec_t;

  localparam logic [63:0] P = 64'hF1E2_D3C4_B5A6_9788;
  localparam logic [63:0] M = 64'h0123_4567_89AB_CDEF;
  localparam int NV = 27;

  localparam vec_t VECS [NV] = '{
    '{3'd2, 2'd3, 1'b1, 2'd3, 3'd1, 3'd0, P,   64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b0, 4'd1}, // R1 k1=P
    '{3'd3, 2'd3, 1'b1, 2'd3, 3'd0, 3'd1, 64'd0, 64'd0, 1'b1, P,   1'b0, 64'd0, 8'h00, 1'b0, 4'd2}, // R2 full qword
    '{3'd2, 2'd0, 1'b1, 2'd3, 3'd2, 3'd0, P,   64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b0, 4'd1}, // R1 byte
    '{3'd3, 2'd3, 1'b1, 2'd3, 3'd0, 3'd2, 64'd0, 64'd0, 1'b1, 64'h88, 1'b0, 64'd0, 8'h00, 1'b0, 4'd1}, // R1 zext
    '{3'd2, 2'd1, 1'b1, 2'd3, 3'd3, 3'd0, P,   64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b0, 4'd1}, // R1 word
    '{3'd3, 2'd3, 1'b1, 2'd3, 3'd0, 3'd3, 64'd0, 64'd0, 1'b1, 64'h9788, 1'b0, 64'd0, 8'h00, 1'b0, 4'd1}, // R1
    '{3'd3, 2'd0, 1'b1, 2'd3, 3'd0, 3'd3, 64'd0, 64'd0, 1'b1, 64'h88, 1'b0, 64'd0, 8'h00, 1'b0, 4'd2}, // R2 byte
    '{3'd1, 2'd2, 1'b1, 2'd0, 3'd0, 3'd1, 64'd0, 64'd0, 1'b0, 64'd0, 1'b1, 64'hB5A69788, 8'h0F, 1'b0, 4'd3}, // R3 dword
    '{3'd1, 2'd3, 1'b1, 2'd2, 3'd0, 3'd1, 64'd0, 64'd0, 1'b0, 64'd0, 1'b1, P, 8'hFF, 1'b0, 4'd3}, // R3 qword
    '{3'd1, 2'd0, 1'b1, 2'd1, 3'd0, 3'd1, 64'd0, 64'd0, 1'b0, 64'd0, 1'b1, 64'h88, 8'h01, 1'b0, 4'd3}, // R3 byte
    '{3'd1, 2'd1, 1'b1, 2'd0, 3'd0, 3'd1, 64'd0, 64'd0, 1'b0, 64'd0, 1'b1, 64'h9788, 8'h03, 1'b0, 4'd3}, // R3 word
    '{3'd0, 2'd1, 1'b1, 2'd0, 3'd4, 3'd1, 64'd0, M, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b0, 4'd8}, // R8 from mem
    '{3'd3, 2'd3, 1'b1, 2'd3, 3'd0, 3'd4, 64'd0, 64'd0, 1'b1, 64'hCDEF, 1'b0, 64'd0, 8'h00, 1'b0, 4'd8}, // R8
    '{3'd0, 2'd2, 1'b1, 2'd3, 3'd5, 3'd1, 64'd0, M, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b0, 4'd8}, // R8 from k1
    '{3'd3, 2'd3, 1'b1, 2'd3, 3'd0, 3'd5, 64'd0, 64'd0, 1'b1, 64'hB5A69788, 1'b0, 64'd0, 8'h00, 1'b0, 4'd8}, // R8
    '{3'd3, 2'd3, 1'b0, 2'd3, 3'd0, 3'd1, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b1, 4'd6}, // R6
    '{3'd2, 2'd3, 1'b0, 2'd3, 3'd1, 3'd0, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b1, 4'd6}, // R6 no write
    '{3'd2, 2'd0, 1'b1, 2'd2, 3'd1, 3'd0, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b1, 4'd4}, // R4 mem mod
    '{3'd3, 2'd3, 1'b1, 2'd0, 3'd0, 3'd1, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b1, 4'd4}, // R4
    '{3'd1, 2'd3, 1'b1, 2'd3, 3'd0, 3'd1, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b1, 4'd5}, // R5
    '{3'd4, 2'd3, 1'b1, 2'd3, 3'd1, 3'd0, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b1, 4'd7}, // R7
    '{3'd5, 2'd3, 1'b1, 2'd0, 3'd1, 3'd0, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b1, 4'd7}, // R7
    '{3'd3, 2'd3, 1'b1, 2'd3, 3'd0, 3'd1, 64'd0, 64'd0, 1'b1, P,   1'b0, 64'd0, 8'h00, 1'b0, 4'd4}, // R4 R6 R7 k1 intact
    '{3'd3, 2'd2, 1'b0, 2'd3, 3'd0, 3'd1, 64'd0, 64'd0, 1'b1, 64'hB5A69788, 1'b0, 64'd0, 8'h00, 1'b0, 4'd2}, // R2 32-bit mode
    '{3'd2, 2'd2, 1'b0, 2'd3, 3'd6, 3'd0, P,   64'd0, 1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b0, 4'd1}, // R1
    '{3'd3, 2'd3, 1'b1, 2'd3, 3'd0, 3'd6, 64'd0, 64'd0, 1'b1, 64'hB5A69788, 1'b0, 64'd0, 8'h00, 1'b0, 4'd1}, // R1
    '{3'd0, 2'd3, 1'b1, 2'd1, 3'd7, 3'd0, 64'd0, P,   1'b0, 64'd0, 1'b0, 64'd0, 8'h00, 1'b0, 4'd8}  // R8 qword mem
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_form;
  logic [1:0]  req_size;
  logic        req_mode64;
  logic [1:0]  req_mod;
  logic [2:0]  req_kdst, req_ksrc;
  logic [63:0] gpr_src, mem_ld;
  logic        gpr_we, st_valid, fault;
  logic [63:0] gpr_wdata, st_data;
  logic [7:0]  st_be;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  maskmov_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_form(req_form),
    .req_size(req_size), .req_mode64(req_mode64), .req_mod(req_mod),
    .req_kdst(req_kdst), .req_ksrc(req_ksrc), .gpr_src(gpr_src),
    .mem_ld(mem_ld), .gpr_we(gpr_we), .gpr_wdata(gpr_wdata),
    .st_valid(st_valid), .st_data(st_data), .st_be(st_be), .fault(fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] f, input logic [1:0] s, input logic m, input logic [1:0] md,
                       input logic [2:0] kd, input logic [2:0] ks, input logic [63:0] g, input logic [63:0] ld);
    req_valid = 1'b1; req_form = f; req_size = s; req_mode64 = m; req_mod = md;
    req_kdst = kd; req_ksrc = ks; gpr_src = g; mem_ld = ld;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_form = '0; req_size = '0; req_mode64 = 1'b1; req_mod = '0;
    req_kdst = '0; req_ksrc = '0; gpr_src = '0; mem_ld = '0;
  endtask

  task automatic check_quiet(input string tag);
    chk({tag, " gpr_we"}, 64'(gpr_we), 64'd0);
    chk({tag, " st_valid"}, 64'(st_valid), 64'd0);
    chk({tag, " fault"}, 64'(fault), 64'd0);
    chk({tag, " gpr_wdata"}, gpr_wdata, 64'd0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state of outputs
    check_quiet("R9 reset");
    chk("R9 st_be", 64'(st_be), 64'd0);
    // R9 every mask register reads zero after reset
    for (int k = 0; k < 8; k++) begin
      drive(3'd3, 2'd3, 1'b1, 2'd3, 3'd0, 3'(k), 64'd0, 64'd0);
      @(negedge clk);
      idle();
      chk($sformatf("R9 k%0d after reset", k), gpr_wdata, 64'd0);
      chk("R9 read strobe", 64'(gpr_we), 64'd1);
    end

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.form, v.size, v.m64, v.modf, v.kd, v.ks, v.gpr, v.mem);
      @(negedge clk);
      idle();
      chk($sformatf("R%0d vec%0d gpr_we", v.req, i), 64'(gpr_we), 64'(v.gwe));
      chk($sformatf("R%0d vec%0d gpr_wdata", v.req, i), gpr_wdata, v.gd);
      chk($sformatf("R%0d vec%0d st_valid", v.req, i), 64'(st_valid), 64'(v.sv));
      chk($sformatf("R%0d vec%0d st_data", v.req, i), st_data, v.sd);
      chk($sformatf("R%0d vec%0d st_be", v.req, i), 64'(st_be), 64'(v.be));
      chk($sformatf("R%0d vec%0d fault", v.req, i), 64'(fault), 64'(v.flt));
      @(negedge clk);
    end

    // R8 qword memory load into k7, read back through a store
    drive(3'd1, 2'd3, 1'b1, 2'd0, 3'd0, 3'd7, 64'd0, 64'd0);
    @(negedge clk);
    idle();
    chk("R8 k7 store data", st_data, P);
    chk("R8 k7 store be", 64'(st_be), 64'hFF);

    // R10 idle cycle produces nothing
    @(negedge clk);
    check_quiet("R10 idle");

    // R10 back-to-back write then read of k0
    drive(3'd2, 2'd2, 1'b1, 2'd3, 3'd0, 3'd0, 64'hDEAD_BEEF_CAFE_F00D, 64'd0);
    @(negedge clk);
    drive(3'd3, 2'd3, 1'b1, 2'd3, 3'd0, 3'd0, 64'd0, 64'd0);
    @(negedge clk);
    idle();
    chk("R10 back-to-back read", gpr_wdata, 64'hCAFE_F00D);
    chk("R10 back-to-back strobe", 64'(gpr_we), 64'd1);

    // R9 reset mid-run clears previously written registers
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_quiet("R9 second reset");
    drive(3'd3, 2'd3, 1'b1, 2'd3, 3'd0, 3'd1, 64'd0, 64'd0);
    @(negedge clk);
    idle();
    chk("R9 k1 cleared", gpr_wdata, 64'd0);
    drive(3'd1, 2'd3, 1'b1, 2'd0, 3'd0, 3'd7, 64'd0, 64'd0);
    @(negedge clk);
    idle();
    chk("R9 k7 cleared", st_data, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule